// File: doc/BRIEF.md
# Loadable Up/Down Counter with Registered Gray Output

This block is a synchronous binary counter with a parallel load, a count enable and a direction select. It also produces a Gray-coded copy of the count that another clock domain can sample. Both outputs come straight from flip-flops, so neither output glitches. The next-state value comes from one combinational block that feeds the state register.

That block makes a single adder serve both directions. It adds a constant whose lowest bit is 1 and whose upper bits all equal the inverted direction select. Counting up therefore adds one, and counting down adds the all-ones value, which is minus one modulo 2^WIDTH.

XOR gates turn the registered binary count into Gray code. A second register on the same clock then captures that code, so gate-level hazards on the XOR outputs never reach the pin. As a result the Gray output trails the binary count by one clock. A typical use is the pointer of a FIFO whose two ports run on different clocks. The receiving side must provide its own synchronisers.

Top module: `updn_gray_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `count_q` and `gray_q` to zero. This takes priority over load and count.
- R2: When `load_n` is 0 at an edge and `rst` is 0, `count_q` takes the value of `din` at that edge, whatever `en` and `up` are.
- R3: When `load_n`=1, `en`=1 and `up`=1, `count_q` increases by one at the edge. From 2^WIDTH-1 it wraps to 0.
- R4: When `load_n`=1, `en`=1 and `up`=0, `count_q` decreases by one at the edge. From 0 it wraps to 2^WIDTH-1.
- R5: When `load_n`=1 and `en`=0, `count_q` keeps its value, whatever `up` and `din` are.
- R6: Outside reset, `gray_q` equals G applied to the value `count_q` held one clock earlier, where G(v) = v XOR (v >> 1).
- R7: Whenever `count_q` changes by exactly ±1 modulo 2^WIDTH, `gray_q` changes in exactly one bit position one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low, highest priority after reset |
| en | input | 1 | Count enable, active high |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Value loaded when `load_n` is low |
| count_q | output | WIDTH | Binary count, driven directly by flip-flops |
| gray_q | output | WIDTH | Gray code of the previous count, re-registered |

## Verification
The bench builds the counter at its default width of 4. At that width every one of the sixteen load values, and every transition out of each count value in both directions, can be visited in a few hundred cycles. These runs include both wrap points (15 to 0 and 0 to 15). They also include loads that arrive together with an active enable in either direction, and hold cycles during which `din` and `up` toggle. Because the sweep covers every count value, it checks the one-bit Gray change on every up and down step of the full code ring. It also checks the one-cycle lag of the Gray output after a load or a reset.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

   // Selected action of the next-state logic, in priority order.
   typedef enum logic [1:0] {
      GC_LOAD = 2'd0,
      GC_STEP = 2'd1,
      GC_HOLD = 2'd2
   } gc_action_e;

   function automatic gc_action_e gc_decode(input logic load_n, input logic en);
      if (!load_n)
         return GC_LOAD;
      else if (en)
         return GC_STEP;
      else
         return GC_HOLD;
   endfunction

endpackage

// File: rtl/gcnt_next.sv
module gcnt_next
   import gcnt_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] din,
   input  logic             load_n,
   input  logic             en,
   input  logic             up,
   output logic [WIDTH-1:0] nxt
);

   localparam int HI = WIDTH - 1;

   gc_action_e              action;
   logic       [WIDTH-1:0]  step_const;

   // Up adds one; down adds the all-ones pattern (minus one).
   assign step_const = {{HI{~up}}, 1'b1};
   assign action     = gc_decode(load_n, en);

   always_comb begin
      nxt = cur;
      unique case (action)
         GC_LOAD: nxt = din;
         GC_STEP: nxt = cur + step_const;
         GC_HOLD: nxt = cur;
         default: nxt = cur;
      endcase
   end

endmodule

// File: rtl/gcnt_reg.sv
module gcnt_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            q[b] <= 1'b0;
         else
            q[b] <= d[b];
      end
   end

endmodule

// File: rtl/gcnt_bin2gray.sv
module gcnt_bin2gray #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] bin,
   output logic [WIDTH-1:0] gray
);

   localparam int MSB = WIDTH - 1;

   assign gray[MSB] = bin[MSB];

   for (genvar b = 0; b < MSB; b++) begin : g_xor
      assign gray[b] = bin[b] ^ bin[b+1];
   end

endmodule

// File: rtl/updn_gray_counter.sv
module updn_gray_counter #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic             en,
   input  logic             up,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count_q,
   output logic [WIDTH-1:0] gray_q
);

   initial begin
      assert (WIDTH >= 2) else $error("updn_gray_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] count_d;
   logic [WIDTH-1:0] gray_d;

   gcnt_next #(.WIDTH(WIDTH)) u_next (
      .cur    (count_q),
      .din    (din),
      .load_n (load_n),
      .en     (en),
      .up     (up),
      .nxt    (count_d)
   );

   gcnt_reg #(.WIDTH(WIDTH)) u_count_reg (
      .clk (clk),
      .rst (rst),
      .d   (count_d),
      .q   (count_q)
   );

   gcnt_bin2gray #(.WIDTH(WIDTH)) u_b2g (
      .bin  (count_q),
      .gray (gray_d)
   );

   gcnt_reg #(.WIDTH(WIDTH)) u_gray_reg (
      .clk (clk),
      .rst (rst),
      .d   (gray_d),
      .q   (gray_q)
   );

endmodule

// File: rtl/gcnt_checker.sv
module gcnt_checker #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             load_n,
   input logic             en,
   input logic             up,
   input logic [WIDTH-1:0] din,
   input logic [WIDTH-1:0] count_q,
   input logic [WIDTH-1:0] gray_q
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic             armed;
   logic             rst_d;
   logic [WIDTH-1:0] cnt_d;
   logic [WIDTH-1:0] exp_gray;
   logic             unit_step;

   // armed: at least two edges seen, the most recent with reset low.
   always_ff @(posedge clk) begin
      rst_d <= rst;
      cnt_d <= count_q;
      armed <= (rst_d === 1'b1 || armed) && !rst;
   end

   always_comb begin
      exp_gray = cnt_d;
      for (int i = 0; i < WIDTH - 1; i++) exp_gray[i] = cnt_d[i] ^ cnt_d[i+1];
   end

   assign unit_step = (count_q == cnt_d + ONE) || (count_q + ONE == cnt_d);

   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (count_q == '0) && (gray_q == '0));

   assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> count_q == $past(din));

   assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
      (load_n && en && up) |=> count_q == $past(count_q) + ONE);

   assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
      (load_n && en && !up) |=> count_q + ONE == $past(count_q));

   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (load_n && !en) |=> $stable(count_q));

   assert_gray_lag_R6: assert property (@(posedge clk) disable iff (rst)
      armed |-> gray_q == exp_gray);

   assert_gray_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
      (armed && unit_step) |=> $countones(gray_q ^ $past(gray_q)) == 1);

endmodule

bind updn_gray_counter gcnt_checker #(.WIDTH(WIDTH)) u_gcnt_checker (
   .clk     (clk),
   .rst     (rst),
   .load_n  (load_n),
   .en      (en),
   .up      (up),
   .din     (din),
   .count_q (count_q),
   .gray_q  (gray_q)
);

// File: tb/updn_gray_counter_tb.sv
`timescale 1ns/1ps
module updn_gray_counter_tb;

   localparam int W = 4;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load_n = 1'b1;
   logic         en = 1'b0;
   logic         up = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] count_q;
   logic [W-1:0] gray_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   int exp_cnt  = 0;
   int exp_gray = 0;
   int prev_gray_obs = 0;
   bit unit_pending = 0;

   always #4 clk = ~clk;

   updn_gray_counter #(.WIDTH(W)) u_dut (
      .clk(clk), .rst(rst), .load_n(load_n), .en(en), .up(up),
      .din(din), .count_q(count_q), .gray_q(gray_q)
   );

   function automatic int to_gray(input int v);
      return (v ^ (v >> 1)) % MOD;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Called just after a negative edge. Applies inputs for one rising edge,
   // then checks at the following negative edge.
   task automatic step(input bit r, input bit ld_n, input bit e, input bit u,
                       input int d, input string req);
      int prev;
      int ones;
      bit was_unit;
      rst = r; load_n = ld_n; en = e; up = u; din = W'(d);
      prev = exp_cnt;
      was_unit = unit_pending;
      @(negedge clk);
      if (r) begin
         exp_cnt = 0; exp_gray = 0;
      end else begin
         exp_gray = to_gray(prev);
         if (!ld_n)     exp_cnt = d % MOD;
         else if (e)    exp_cnt = u ? (prev + 1) % MOD : (prev + MOD - 1) % MOD;
      end
      check(req, int'(count_q), exp_cnt);
      check(r ? "R1" : "R6", int'(gray_q), exp_gray);
      if (was_unit && !r) begin
         ones = $countones(W'(gray_q) ^ W'(prev_gray_obs));
         check("R7", ones, 1);
      end
      unit_pending = !r && (((prev + 1) % MOD == exp_cnt) || ((exp_cnt + 1) % MOD == prev));
      prev_gray_obs = int'(gray_q);
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      step(1, 1, 0, 1, 0, "R1");
      step(1, 0, 1, 1, 9, "R1");          // reset beats load
      // Every load value, with en active both ways (load priority, R2)
      for (int v = 0; v < MOD; v++) begin
         step(0, 0, v[0], v[1], v, "R2");
         step(0, 1, 0, ~v[0], (v * 7) % MOD, "R5");   // hold while din/up wiggle
      end
      // Full ring upward from a load, including 15 -> 0 wrap
      step(0, 0, 0, 0, 13, "R2");
      for (int i = 0; i < MOD + 3; i++) step(0, 1, 1, 1, i % MOD, "R3");
      // Full ring downward, including 0 -> 15 wrap
      step(0, 0, 1, 1, 2, "R2");
      for (int i = 0; i < MOD + 3; i++) step(0, 1, 1, 0, (i * 5) % MOD, "R4");
      // Enable toggling with direction changes
      for (int i = 0; i < 3 * MOD; i++) begin
         bit e = (i % 3) != 2;
         bit u = (i % 5) < 2;
         step(0, 1, e, u, i % MOD, e ? (u ? "R3" : "R4") : "R5");
      end
      // Explicit wrap points
      step(0, 0, 0, 1, MOD - 1, "R2");
      step(0, 1, 1, 1, 0, "R3");
      step(0, 1, 1, 0, 0, "R4");
      // Reset mid-count, then resume
      step(0, 0, 0, 0, 11, "R2");
      step(1, 1, 1, 1, 0, "R1");
      step(0, 1, 1, 0, 0, "R4");
      step(0, 1, 0, 1, 0, "R5");
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule